// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Controller

This block owns the clock-enable line of an SDRAM and decides when the device stops seeing clock edges. A single request to lower clock-enable does one of two things, depending on the bank status reported by the bank tracker. If every bank is idle, the device goes into power-down. If any row is still open, it goes into clock suspend instead, with output and burst state held frozen. The controller reports which of the two it chose on a two-bit mode output.

While clock-enable is low, the block withdraws its command-ready signal, so the command issuer sends only NOPs. An exit request raises clock-enable at the next edge. Command-ready then stays low for a parameterised number of recovery cycles (one by default) before commands may flow again. An enter request that arrives during recovery is held. It is acted on when recovery ends, and the choice between suspend and power-down is made from the bank status at that moment.

Top module: `cke_pd_ctrl`

## Requirements
- R1: After reset, cke is 1, cmd_ready is 1 and mode is 2'b00 (running).
- R2: An enter_req sampled while running with all_idle = 1 makes cke 0 and mode 2'b10 (power-down) from the next clock edge.
- R3: An enter_req sampled while running with all_idle = 0 makes cke 0 and mode 2'b01 (clock suspend) from the next clock edge.
- R4: While cke is 0, cmd_ready is 0; enter_req and changes of all_idle are ignored, and mode keeps its value.
- R5: An exit_req sampled while cke is 0 raises cke and sets mode to 2'b00 at the next edge. cmd_ready then stays 0 for EXIT_CYC cycles (default 1) and returns to 1 afterwards.
- R6: An exit_req sampled while running has no effect: cke, cmd_ready and mode stay 1, 1, 2'b00.
- R7: An enter_req sampled during exit recovery is deferred. cke falls at the edge that ends recovery, and mode is chosen from all_idle at that point (2'b10 if idle, 2'b01 if not).
- R8: When enter_req and exit_req are sampled together, enter wins while running, and exit wins while cke is 0. In the second case the enter request is discarded, not deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request to lower clock-enable |
| exit_req | input | 1 | Request to raise clock-enable |
| all_idle | input | 1 | All banks idle, from the bank tracker |
| cke | output | 1 | SDRAM clock-enable |
| cmd_ready | output | 1 | Command issuer may send non-NOP commands |
| mode | output | 2 | 00 running, 01 clock suspend, 10 power-down |

## Verification
The enter path is driven with all_idle high and low. This tells apart the two low modes, which leave cke identical and differ only in mode. Exit is requested from both low modes, and a plain idle cycle follows each exit. That cycle separates the recovery window from the return of command-ready. Requests are also issued in the wrong state, during recovery and together in one cycle. These patterns show whether each request is ignored, deferred or prioritised, and whether a lost enter would leave cke high when it should have fallen.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SUSP = 2'd1,
        ST_PDN  = 2'd2,
        ST_EXIT = 2'd3
    } pd_state_e;

    localparam logic [1:0] MODE_RUN  = 2'b00;
    localparam logic [1:0] MODE_SUSP = 2'b01;
    localparam logic [1:0] MODE_PDN  = 2'b10;

    typedef struct packed {
        pd_state_e state;
        logic      pend;
    } pd_regs_t;

endpackage

// File: rtl/cke_pd_modesel.sv
module cke_pd_modesel
    import cke_pd_pkg::*;
(
    input  logic      all_idle,
    output pd_state_e low_state
);
    // Lowering CKE with every bank idle is power-down; otherwise clock suspend.
    always_comb begin
        if (all_idle) begin
            low_state = ST_PDN;
        end else begin
            low_state = ST_SUSP;
        end
    end
endmodule

// File: rtl/cke_pd_recov.sv
module cke_pd_recov #(
    parameter int EXIT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(EXIT_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(EXIT_CYC);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == ONE);
endmodule

// File: rtl/cke_pd_outdec.sv
module cke_pd_outdec
    import cke_pd_pkg::*;
(
    input  pd_state_e  state,
    output logic       cke,
    output logic       cmd_ready,
    output logic [1:0] mode
);
    always_comb begin
        cke       = 1'b1;
        cmd_ready = 1'b0;
        mode      = MODE_RUN;
        case (state)
            ST_RUN: begin
                cmd_ready = 1'b1;
            end
            ST_SUSP: begin
                cke  = 1'b0;
                mode = MODE_SUSP;
            end
            ST_PDN: begin
                cke  = 1'b0;
                mode = MODE_PDN;
            end
            default: begin
                cke = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
    import cke_pd_pkg::*;
#(
    parameter int EXIT_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       exit_req,
    input  logic       all_idle,
    output logic       cke,
    output logic       cmd_ready,
    output logic [1:0] mode
);
    pd_regs_t  r_d, r_q;
    pd_state_e low_state;
    logic      rec_start, rec_busy, rec_last;

    cke_pd_modesel u_sel (
        .all_idle  (all_idle),
        .low_state (low_state)
    );

    cke_pd_recov #(.EXIT_CYC(EXIT_CYC)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rec_start),
        .busy  (rec_busy),
        .last  (rec_last)
    );

    always_comb begin
        r_d       = r_q;
        rec_start = 1'b0;
        case (r_q.state)
            ST_RUN: begin
                // enter wins over a simultaneous exit while running
                if (enter_req) begin
                    r_d.state = low_state;
                end
            end
            ST_SUSP, ST_PDN: begin
                // exit wins; a simultaneous enter is dropped
                if (exit_req) begin
                    r_d.state = ST_EXIT;
                    rec_start = 1'b1;
                end
            end
            default: begin
                r_d.pend = r_q.pend | enter_req;
                if (rec_last || !rec_busy) begin
                    r_d.pend  = 1'b0;
                    r_d.state = (r_q.pend || enter_req) ? low_state : ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, pend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    cke_pd_outdec u_dec (
        .state     (r_q.state),
        .cke       (cke),
        .cmd_ready (cmd_ready),
        .mode      (mode)
    );
endmodule

// File: rtl/cke_pd_ctrl_chk.sv
module cke_pd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enter_req,
    input logic       exit_req,
    input logic       all_idle,
    input logic       cke,
    input logic       cmd_ready,
    input logic [1:0] mode
);
    // R2
    pdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && enter_req && all_idle) |=> (!cke && mode == 2'b10));

    // R3
    susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && enter_req && !all_idle) |=> (!cke && mode == 2'b01));

    // R4
    low_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_ready);

    // R4
    low_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !exit_req) |=> (!cke && $stable(mode)));

    // R5
    exit_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && exit_req) |=> (cke && !cmd_ready && mode == 2'b00));

    // R6
    run_ignores_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && exit_req && !enter_req) |=> (cke && cmd_ready));

    // R8
    enter_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && enter_req && exit_req) |=> !cke);
endmodule

bind cke_pd_ctrl cke_pd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_req (enter_req),
    .exit_req  (exit_req),
    .all_idle  (all_idle),
    .cke       (cke),
    .cmd_ready (cmd_ready),
    .mode      (mode)
);

// File: tb/cke_pd_ctrl_test.sv
module cke_pd_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter_req = 1'b0;
    logic       exit_req = 1'b0;
    logic       all_idle = 1'b1;
    logic       cke, cmd_ready;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit driving_done = 1'b0;

    typedef struct {
        logic       e_cke;
        logic       e_rdy;
        logic [1:0] e_mode;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    cke_pd_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_req (enter_req),
        .exit_req  (exit_req),
        .all_idle  (all_idle),
        .cke       (cke),
        .cmd_ready (cmd_ready),
        .mode      (mode)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (cke !== e.e_cke || cmd_ready !== e.e_rdy || mode !== e.e_mode) begin
            errors++;
            $display("FAIL %s: got cke=%b rdy=%b mode=%b, expected cke=%b rdy=%b mode=%b",
                     e.tag, cke, cmd_ready, mode, e.e_cke, e.e_rdy, e.e_mode);
        end
    endtask

    // Drive one cycle of inputs and queue the outputs expected after the next edge.
    task automatic step(input logic en, input logic ex, input logic idle,
                        input logic ecke, input logic erdy, input logic [1:0] emode,
                        input string tag);
        exp_t e;
        @(negedge clk);
        enter_req = en;
        exit_req  = ex;
        all_idle  = idle;
        e.e_cke  = ecke;
        e.e_rdy  = erdy;
        e.e_mode = emode;
        e.tag    = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each edge with the item queued for it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                compare(sb.pop_front());
            end
        end
    end

    initial begin
        exp_t r;
        #12;
        r.e_cke = 1'b1; r.e_rdy = 1'b1; r.e_mode = 2'b00; r.tag = "R1 reset state";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 1, 1, 1, 2'b00, "R1 idle after reset");
        step(0, 1, 1, 1, 1, 2'b00, "R6 exit while running");
        step(1, 0, 1, 0, 0, 2'b10, "R2 enter with banks idle");
        step(0, 0, 0, 0, 0, 2'b10, "R4 all_idle change ignored");
        step(1, 0, 0, 0, 0, 2'b10, "R4 enter while low ignored");
        step(0, 1, 0, 1, 0, 2'b00, "R5 exit from power-down");
        step(0, 0, 0, 1, 1, 2'b00, "R5 ready after recovery");
        step(1, 0, 0, 0, 0, 2'b01, "R3 enter with open bank");
        step(0, 0, 1, 0, 0, 2'b01, "R4 suspend held");
        step(0, 1, 1, 1, 0, 2'b00, "R5 exit from suspend");
        step(1, 0, 1, 0, 0, 2'b10, "R7 enter in recovery, idle");
        step(0, 1, 1, 1, 0, 2'b00, "R5 exit again");
        step(1, 0, 0, 0, 0, 2'b01, "R7 enter in recovery, busy");
        step(1, 1, 0, 1, 0, 2'b00, "R8 exit wins while low");
        step(0, 0, 0, 1, 1, 2'b00, "R8 enter discarded");
        step(1, 1, 1, 0, 0, 2'b10, "R8 enter wins while running");
        step(0, 1, 1, 1, 0, 2'b00, "R5 final exit");
        step(0, 0, 1, 1, 1, 2'b00, "R5 final ready");
        @(negedge clk);
        enter_req = 1'b0;
        exit_req  = 1'b0;
        driving_done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!(driving_done && sb.size() == 0) && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 2000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        #5;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule